// File: doc/BRIEF.md
# Key Slot Free-List Allocator

This block hands out key-storage slot numbers to a cipher engine and takes them back. It holds every unused slot number in a first-in-first-out free list, so slots are reused in the order they were returned. One slot holds a secure key that is installed at boot. That slot is never part of the free list, is never granted, and a request to return it has no effect.

A client pulses `alloc_req` for one cycle to ask for a slot. On the next clock edge the block answers with either `alloc_ok` and a slot number, or `alloc_fail` when no slot is free. A client pulses `rel_req` with a slot number on `rel_slot` to give a slot back. If a release arrives for a slot that is already free, the block drops that release and raises a sticky double-free flag. The `free_count` output always shows how many slots can still be granted.

Top module: `keyslot_alloc`

## Requirements
- R1: After reset, `free_count` is 7, and `dbl_free_err`, `alloc_ok` and `alloc_fail` are all 0. Allocations made straight after reset return slots 0, 1, 2, 3, 5, 6 and 7, in that order.
- R2: Slot 4 (`RSVD_SLOT`) is never granted, and it is never counted as free.
- R3: A release of a slot that is in use and is not slot 4 appends that slot to the tail of the free list. Allocations take slots from the head, so released slots come back in the order they were released.
- R4: An allocation request made while no slot is free gives `alloc_fail`=1 and `alloc_ok`=0. `alloc_ok` and `alloc_fail` are never high together.
- R5: A release of slot 4 is ignored. It changes neither `free_count` nor `dbl_free_err`, and slot 4 is not granted afterwards.
- R6: When a release and an allocation arrive in the same cycle, the release is appended before the allocation is served. On an empty list, the allocation is therefore granted the slot being released.
- R7: A release of a slot that is already free is ignored and sets `dbl_free_err`. The flag stays at 1 until reset.
- R8: `free_count` equals the number of slots currently free. Its range is 0 to 7.
- R9: The response to a request appears on the clock edge that samples the request, and lasts one cycle. `alloc_slot` is valid whenever `alloc_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | One-cycle pulse that asks for a slot |
| rel_req | input | 1 | One-cycle pulse that returns a slot |
| rel_slot | input | 3 | Number of the slot being returned |
| alloc_ok | output | 1 | Registered pulse: a slot was granted |
| alloc_fail | output | 1 | Registered pulse: no slot was free |
| alloc_slot | output | 3 | Granted slot number, valid while `alloc_ok` is 1 |
| free_count | output | 3 | Number of slots currently free |
| dbl_free_err | output | 1 | Sticky flag: a release of an already-free slot was seen |

## Verification
The bench builds the block with its default values: eight slots, with slot 4 reserved. At this size every slot can be drained and refilled in a few cycles. Short runs therefore reach the empty list, the full list, and the case where the read and write pointers of the ring wrap around. Directed sequences cover the reset order, releases of the reserved slot, same-cycle bypass on an empty list, and double frees. A long mixed phase then mixes releases of both free and in-use slots with allocations, and checks each cycle against a queue model.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;

  // Slot number held by ring entry idx at reset: ascending order with the reserved slot skipped.
  function automatic int unsigned reset_entry(input int unsigned idx, input int unsigned rsvd);
    return (idx < rsvd) ? idx : idx + 1;
  endfunction

endpackage

// File: rtl/ks_slot_ring.sv
module ks_slot_ring #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned RSVD_SLOT = 4,
  localparam int unsigned SW    = $clog2(NUM_SLOTS),
  localparam int unsigned DEPTH = NUM_SLOTS - 1,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [SW-1:0] push_slot,
  input  logic          pop,
  output logic [SW-1:0] head_slot,
  output logic [CW-1:0] count
);
  import keyslot_pkg::*;

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [SW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // An empty ring passes the incoming slot straight through, so a pop in the same cycle sees it.
  assign head_slot = (cnt_q == '0) ? push_slot : mem_q[rd_q];
  assign count     = cnt_q;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(DEPTH);
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic we;
    assign we = push && (wr_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[i] <= SW'(reset_entry(i, RSVD_SLOT));
      else if (we) mem_q[i] <= push_slot;
    end
  end

  AST_RING_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH)) |-> !(push && !pop)); // R8
  AST_RING_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop) |-> push); // R4

endmodule

// File: rtl/ks_free_map.sv
module ks_free_map #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned RSVD_SLOT = 4,
  localparam int unsigned SW = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rel_req,
  input  logic [SW-1:0]        rel_slot,
  input  logic                 grant,
  input  logic [SW-1:0]        grant_slot,
  output logic                 rel_accept,
  output logic                 dbl_hit,
  output logic [NUM_SLOTS-1:0] free_bits
);

  logic [NUM_SLOTS-1:0] bits_q, bits_d;
  logic                 rel_ok_slot;
  logic                 rel_is_free;

  assign rel_ok_slot = (32'(rel_slot) < NUM_SLOTS) && (32'(rel_slot) != RSVD_SLOT);
  assign rel_is_free = bits_q[rel_slot];
  assign rel_accept  = rel_req && rel_ok_slot && !rel_is_free;
  assign dbl_hit     = rel_req && rel_ok_slot && rel_is_free;
  assign free_bits   = bits_q;

  // The release is applied first and the grant second, so a slot passed through on an empty list ends up in use.
  always_comb begin
    bits_d = bits_q;
    if (rel_accept) bits_d[rel_slot]   = 1'b1;
    if (grant)      bits_d[grant_slot] = 1'b0;
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_bit
    logic en;
    assign en = (bits_d[i] != bits_q[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bits_q[i] <= (i != RSVD_SLOT);
      else if (en) bits_q[i] <= bits_d[i];
    end
  end

  AST_RSVD_NEVER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !bits_q[RSVD_SLOT]); // R2
  AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (bits_q[grant_slot] || (rel_accept && rel_slot == grant_slot))); // R3

endmodule

// File: rtl/keyslot_alloc.sv
module keyslot_alloc #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned RSVD_SLOT = 4,
  localparam int unsigned SW = $clog2(NUM_SLOTS),
  localparam int unsigned CW = $clog2(NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          rel_req,
  input  logic [SW-1:0] rel_slot,
  output logic          alloc_ok,
  output logic          alloc_fail,
  output logic [SW-1:0] alloc_slot,
  output logic [CW-1:0] free_count,
  output logic          dbl_free_err
);

  logic                 rel_accept, dbl_hit, grant;
  logic [SW-1:0]        head_slot;
  logic [CW-1:0]        ring_cnt;
  logic [NUM_SLOTS-1:0] free_bits;

  logic          ok_q, ok_d, fail_q, fail_d, err_q, err_d;
  logic [SW-1:0] slot_q, slot_d;
  logic          slot_en;

  // A grant is possible when the list holds a slot or a release is being appended this cycle.
  assign grant = alloc_req && ((ring_cnt != '0) || rel_accept);

  ks_free_map #(.NUM_SLOTS(NUM_SLOTS), .RSVD_SLOT(RSVD_SLOT)) map_i (
    .clk(clk), .rst_n(rst_n),
    .rel_req(rel_req), .rel_slot(rel_slot),
    .grant(grant), .grant_slot(head_slot),
    .rel_accept(rel_accept), .dbl_hit(dbl_hit), .free_bits(free_bits)
  );

  ks_slot_ring #(.NUM_SLOTS(NUM_SLOTS), .RSVD_SLOT(RSVD_SLOT)) ring_i (
    .clk(clk), .rst_n(rst_n),
    .push(rel_accept), .push_slot(rel_slot),
    .pop(grant), .head_slot(head_slot), .count(ring_cnt)
  );

  always_comb begin
    ok_d    = grant;
    fail_d  = alloc_req && !grant;
    err_d   = err_q || dbl_hit;
    slot_en = grant;
    slot_d  = head_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ok_q   <= ok_d;
      fail_q <= fail_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= '0;
    else if (slot_en) slot_q <= slot_d;
  end

  assign alloc_ok     = ok_q;
  assign alloc_fail   = fail_q;
  assign alloc_slot   = slot_q;
  assign free_count   = ring_cnt;
  assign dbl_free_err = err_q;

  AST_NO_RSVD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |-> (32'(alloc_slot) != RSVD_SLOT)); // R2
  AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_ok && alloc_fail)); // R4
  AST_FAIL_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fail |-> (free_count == '0)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_free_err |=> dbl_free_err); // R7
  AST_COUNT_MATCHES_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(free_bits) == int'(free_count)); // R8
  AST_RSVD_REL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && 32'(rel_slot) == RSVD_SLOT && !alloc_req) |=> $stable(free_count)); // R5
  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> (alloc_ok || alloc_fail)); // R9

endmodule

// File: tb/keyslot_alloc_tb_top.sv
module keyslot_alloc_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       alloc_req, rel_req;
  logic [2:0] rel_slot;
  logic       alloc_ok, alloc_fail, dbl_free_err;
  logic [2:0] alloc_slot, free_count;

  int checks = 0;
  int errors = 0;

  int  fl[$];
  bit  mfree[8];
  bit  merr;

  always #4 clk = ~clk;

  keyslot_alloc dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .rel_req(rel_req), .rel_slot(rel_slot),
    .alloc_ok(alloc_ok), .alloc_fail(alloc_fail), .alloc_slot(alloc_slot),
    .free_count(free_count), .dbl_free_err(dbl_free_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    fl.delete();
    for (int i = 0; i < 8; i++) begin
      mfree[i] = (i != 4);
      if (i != 4) fl.push_back(i);
    end
    merr = 1'b0;
  endtask

  task automatic do_reset();
    alloc_req = 1'b0; rel_req = 1'b0; rel_slot = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk("R1 reset free_count", int'(free_count), 7);
    chk("R1 reset dbl_free_err", int'(dbl_free_err), 0);
    chk("R1 reset alloc_ok", int'(alloc_ok), 0);
    chk("R1 reset alloc_fail", int'(alloc_fail), 0);
  endtask

  // Drive one cycle at a falling edge, then compare at the next falling edge.
  task automatic step(input bit a, input bit r, input int s, input string tag);
    bit eok, efail;
    int eslot;
    alloc_req = a; rel_req = r; rel_slot = 3'(s);
    eok = 0; efail = 0; eslot = -1;
    if (r && s != 4) begin
      if (mfree[s]) merr = 1'b1;
      else begin fl.push_back(s); mfree[s] = 1'b1; end
    end
    if (a) begin
      if (fl.size() > 0) begin eslot = fl.pop_front(); mfree[eslot] = 1'b0; eok = 1; end
      else efail = 1;
    end
    @(posedge clk);
    @(negedge clk);
    alloc_req = 1'b0; rel_req = 1'b0;
    chk({tag, " R9 alloc_ok"}, int'(alloc_ok), int'(eok));
    chk({tag, " R4 alloc_fail"}, int'(alloc_fail), int'(efail));
    if (eok) begin
      chk({tag, " R3 alloc_slot"}, int'(alloc_slot), eslot);
      if (alloc_slot == 3'd4) chk({tag, " R2 reserved granted"}, int'(alloc_slot), -1);
    end
    chk({tag, " R8 free_count"}, int'(free_count), fl.size());
    chk({tag, " R7 dbl_free_err"}, int'(dbl_free_err), int'(merr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset order, then the list runs dry (R4)
    for (int i = 0; i < 7; i++) step(1, 0, 0, "R1 drain");
    step(1, 0, 0, "R4 empty");
    // R5: releasing the reserved slot does nothing, even with an allocation beside it
    step(0, 1, 4, "R5 rsvd");
    step(1, 1, 4, "R5 rsvd+alloc");
    // R3: FIFO return order
    step(0, 1, 3, "R3 rel");
    step(0, 1, 1, "R3 rel");
    step(0, 1, 6, "R3 rel");
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R3 order");
    // R6: bypass on an empty list
    step(1, 1, 2, "R6 bypass");
    step(0, 1, 7, "R6 rel");
    step(1, 1, 0, "R6 append first");
    step(1, 0, 0, "R6 tail");
    // R7: double free
    step(0, 1, 5, "R7 rel");
    step(0, 1, 5, "R7 double");
    step(0, 0, 0, "R7 sticky");
    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      int s;
      s = $urandom_range(0, 7);
      step(($urandom_range(0, 2) == 0), ($urandom_range(0, 1) == 0), s, "mix");
    end
    // R1: reset clears the sticky flag and restores the order
    do_reset();
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R1 after reset");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule